// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind a bit-level I2C front end that turns the serial line into whole bytes and single-cycle strobes for start, repeated start and stop. It examines the first byte (or, in 10-bit addressing, the first two bytes) after each start and decides whether the device is being addressed. On a hit it requests an acknowledge, raises a sticky "address matched" flag with an optional event interrupt, and records the transfer direction and which of its two own addresses was hit.

In 10-bit addressing a write header plus the low address byte selects the device as a receiver. The match is then remembered until the next stop or plain start. A repeated start followed by a read header with the right two high address bits moves the device to transmitter mode without resending the low byte. Bytes that follow a decided address phase are data and are left alone.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (tenBitMode=0), a byte after a start whose bits [7:1] equal ownAddr1[6:0] is a match: ackOut is high for exactly the one cycle after the byteValid cycle, and addrMatched is 1 from that same cycle on.
- R2: ackOut is only raised when ackEnable was 1 in the byteValid cycle; with ackEnable=0 a match still sets addrMatched but ackOut stays 0.
- R3: A byte whose bits [7:1] equal ownAddr2 matches only while dualEnable=1 and sets dualHit=1; a match on ownAddr1 sets dualHit=0; with dualEnable=0 such a byte gets no ack and leaves addrMatched at 0.
- R4: On a 7-bit match txMode takes bit 0 of the address byte (1 = transmitter, 0 = receiver); a stop, start or repeated start clears txMode to 0.
- R5: In 10-bit mode a header 11110 a9 a8 0 (bits [7:3]=11110, bits [2:1]=ownAddr1[9:8], bit 0=0) is acked without setting addrMatched; a following byte equal to ownAddr1[7:0] is acked, sets addrMatched and leaves txMode=0; any other second byte is not acked.
- R6: In 10-bit mode a read header 11110 a9 a8 1 is acked, sets addrMatched and sets txMode=1 only when it comes after a repeated start that followed a completed 10-bit write match with no stop or plain start in between; otherwise it is not acked.
- R7: evtIrq is 1 exactly while addrMatched=1 and evtIrqEnable=1.
- R8: addrMatched clears only when a sr1Read pulse is followed later by a sr2Read pulse while it is set; a sr2Read without a preceding sr1Read leaves it set.
- R9: A non-matching address byte and a stop both return the matcher to idle: later bytes get no ack until the next start or repeated start, and bytes after a completed match are not acked either.
- R10: In 10-bit mode a header whose bits [2:1] differ from ownAddr1[9:8] is not acked and sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe: byteData holds a received byte |
| byteData | input | 8 | Received byte, MSB first as on the bus |
| startStb | input | 1 | Start condition seen |
| rstartStb | input | 1 | Repeated start seen |
| stopStb | input | 1 | Stop condition seen |
| tenBitMode | input | 1 | 1 = 10-bit own address, 0 = 7-bit |
| dualEnable | input | 1 | Enables the second 7-bit own address |
| ackEnable | input | 1 | Allows the acknowledge request |
| evtIrqEnable | input | 1 | Enables the event interrupt |
| ownAddr1 | input | 10 | Primary own address (7-bit mode uses [6:0]) |
| ownAddr2 | input | 7 | Second own address |
| sr1Read | input | 1 | Status-read step one pulse |
| sr2Read | input | 1 | Status-read step two pulse |
| ackOut | output | 1 | Acknowledge request for the last byte |
| addrMatched | output | 1 | Sticky address-matched flag |
| dualHit | output | 1 | 1 when the last match was on ownAddr2 |
| txMode | output | 1 | 1 = transmitter, 0 = receiver |
| evtIrq | output | 1 | Event interrupt |

## Verification
On every cycle the assertions check that an acknowledge is never raised without the enable and a byte one cycle earlier, that the matched flag only rises from a match strobe and only falls after the second status read, that dualHit never rises with dual addressing off, that a stop forces idle, and that an unarmed 10-bit read header is never acknowledged. What only the bench scenarios can show is whether the whole address sequences are resolved correctly. That covers the 7-bit compare and direction bit, the two-byte 10-bit write followed by the repeated-start read turn-around, the loss of that memory across a stop, rejection of wrong high or low address bits, and the ordering of the two-step flag clear.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int BYTE_W  = 8;
  localparam int SHORT_W = 7;
  localparam int LONG_W  = 10;
  localparam int HI_W    = LONG_W - BYTE_W;
  localparam int TAG_W   = BYTE_W - HI_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_LOW,
    ST_DONE
  } amState_t;

  // Comparison results from the datapath to the control
  typedef struct packed {
    logic hit1;
    logic hit2;
    logic hdrHit;
    logic lowHit;
    logic rwBit;
  } amCmp_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic setMatch;
    logic slot2;
    logic dirTx;
    logic clrDir;
  } amStb_t;

endpackage

// File: rtl/am_datapath.sv
module am_datapath
  import i2c_am_pkg::*;
#(
  parameter logic [TAG_W-1:0] HDR_TAG = 5'b11110
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   byteData,
  input  logic                dualEnable,
  input  logic                evtIrqEnable,
  input  logic [LONG_W-1:0]   ownAddr1,
  input  logic [SHORT_W-1:0]  ownAddr2,
  input  logic                sr1Read,
  input  logic                sr2Read,
  input  amStb_t              stb,
  output amCmp_t              cmp,
  output logic                addrMatched,
  output logic                dualHit,
  output logic                txMode,
  output logic                evtIrq
);

  logic matchFlag;
  logic sr1Seen;

  // Address comparators
  always_comb begin
    cmp.hit1   = (byteData[BYTE_W-1:1] == ownAddr1[SHORT_W-1:0]);
    cmp.hit2   = dualEnable && (byteData[BYTE_W-1:1] == ownAddr2);
    cmp.hdrHit = (byteData[BYTE_W-1:HI_W+1] == HDR_TAG) &&
                 (byteData[HI_W:1] == ownAddr1[LONG_W-1:BYTE_W]);
    cmp.lowHit = (byteData == ownAddr1[BYTE_W-1:0]);
    cmp.rwBit  = byteData[0];
  end

  // Matched flag with two-step clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      sr1Seen   <= 1'b0;
    end else if (stb.setMatch) begin
      matchFlag <= 1'b1;
      sr1Seen   <= 1'b0;
    end else if (matchFlag && sr1Seen && sr2Read) begin
      matchFlag <= 1'b0;
      sr1Seen   <= 1'b0;
    end else if (matchFlag && sr1Read) begin
      sr1Seen   <= 1'b1;
    end
  end

  // Direction and address slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dualHit <= 1'b0;
      txMode  <= 1'b0;
    end else if (stb.setMatch) begin
      dualHit <= stb.slot2;
      txMode  <= stb.dirTx;
    end else if (stb.clrDir) begin
      txMode  <= 1'b0;
    end
  end

  assign addrMatched = matchFlag;
  assign evtIrq      = matchFlag & evtIrqEnable;

  a_r8_clear_order: assert property (@(posedge clk) disable iff (!rstN)
    $fell(matchFlag) |-> $past(sr2Read));

  a_r1_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(stb.setMatch));

  a_r3_slot_needs_dual: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dualHit) |-> $past(dualEnable));

  a_r4_tx_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txMode) |-> $past(stb.setMatch));

endmodule

// File: rtl/am_control.sv
module am_control
  import i2c_am_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   byteValid,
  input  logic   startStb,
  input  logic   rstartStb,
  input  logic   stopStb,
  input  logic   tenBitMode,
  input  logic   ackEnable,
  input  amCmp_t cmp,
  output amStb_t stb,
  output logic   ackOut
);

  amState_t state, nextState;
  logic     tenArmed, nextArmed;
  logic     accept;

  always_comb begin
    nextState    = state;
    nextArmed    = tenArmed;
    accept       = 1'b0;
    stb.setMatch = 1'b0;
    stb.slot2    = 1'b0;
    stb.dirTx    = 1'b0;
    stb.clrDir   = 1'b0;
    if (stopStb) begin
      nextState  = ST_IDLE;
      nextArmed  = 1'b0;
      stb.clrDir = 1'b1;
    end else if (startStb) begin
      nextState  = ST_FIRST;
      nextArmed  = 1'b0;
      stb.clrDir = 1'b1;
    end else if (rstartStb) begin
      nextState  = ST_FIRST;
      stb.clrDir = 1'b1;
    end else if (byteValid) begin
      unique case (state)
        ST_FIRST: begin
          if (tenBitMode && cmp.hdrHit) begin
            if (!cmp.rwBit) begin
              accept    = 1'b1;
              nextState = ST_LOW;
            end else if (tenArmed) begin
              accept       = 1'b1;
              stb.setMatch = 1'b1;
              stb.dirTx    = 1'b1;
              nextState    = ST_DONE;
            end else begin
              nextState = ST_IDLE;
            end
          end else if (!tenBitMode && cmp.hit1) begin
            accept       = 1'b1;
            stb.setMatch = 1'b1;
            stb.dirTx    = cmp.rwBit;
            nextState    = ST_DONE;
          end else if (cmp.hit2) begin
            accept       = 1'b1;
            stb.setMatch = 1'b1;
            stb.slot2    = 1'b1;
            stb.dirTx    = cmp.rwBit;
            nextState    = ST_DONE;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_LOW: begin
          if (cmp.lowHit) begin
            accept       = 1'b1;
            stb.setMatch = 1'b1;
            nextArmed    = 1'b1;
            nextState    = ST_DONE;
          end else begin
            nextArmed = 1'b0;
            nextState = ST_IDLE;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tenArmed <= 1'b0;
      ackOut   <= 1'b0;
    end else begin
      state    <= nextState;
      tenArmed <= nextArmed;
      ackOut   <= accept && ackEnable;
    end
  end

  a_r2_ack_gated: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(ackEnable && byteValid));

  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> (state == ST_IDLE));

  a_r6_read_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIRST && byteValid && tenBitMode && cmp.hdrHit && cmp.rwBit &&
     !tenArmed && !stopStb && !startStb && !rstartStb) |=> !ackOut);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        startStb,
  input  logic        rstartStb,
  input  logic        stopStb,
  input  logic        tenBitMode,
  input  logic        dualEnable,
  input  logic        ackEnable,
  input  logic        evtIrqEnable,
  input  logic [9:0]  ownAddr1,
  input  logic [6:0]  ownAddr2,
  input  logic        sr1Read,
  input  logic        sr2Read,
  output logic        ackOut,
  output logic        addrMatched,
  output logic        dualHit,
  output logic        txMode,
  output logic        evtIrq
);

  amCmp_t cmp;
  amStb_t stb;

  am_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .startStb  (startStb),
    .rstartStb (rstartStb),
    .stopStb   (stopStb),
    .tenBitMode(tenBitMode),
    .ackEnable (ackEnable),
    .cmp       (cmp),
    .stb       (stb),
    .ackOut    (ackOut)
  );

  am_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .byteData    (byteData),
    .dualEnable  (dualEnable),
    .evtIrqEnable(evtIrqEnable),
    .ownAddr1    (ownAddr1),
    .ownAddr2    (ownAddr2),
    .sr1Read     (sr1Read),
    .sr2Read     (sr2Read),
    .stb         (stb),
    .cmp         (cmp),
    .addrMatched (addrMatched),
    .dualHit     (dualHit),
    .txMode      (txMode),
    .evtIrq      (evtIrq)
  );

endmodule

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic startStb = 1'b0, rstartStb = 1'b0, stopStb = 1'b0;
  logic tenBitMode = 1'b0, dualEnable = 1'b0, ackEnable = 1'b1, evtIrqEnable = 1'b1;
  logic [9:0] ownAddr1 = 10'h2A5;
  logic [6:0] ownAddr2 = 7'h3C;
  logic sr1Read = 1'b0, sr2Read = 1'b0;
  logic ackOut, addrMatched, dualHit, txMode, evtIrq;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  ack;
    logic  flag;
    logic  tx;
    logic  dual;
    string req;
  } exp_t;
  exp_t expQ[$];
  logic tbSaw = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_match u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .startStb(startStb), .rstartStb(rstartStb), .stopStb(stopStb),
    .tenBitMode(tenBitMode), .dualEnable(dualEnable), .ackEnable(ackEnable),
    .evtIrqEnable(evtIrqEnable), .ownAddr1(ownAddr1), .ownAddr2(ownAddr2),
    .sr1Read(sr1Read), .sr2Read(sr2Read), .ackOut(ackOut),
    .addrMatched(addrMatched), .dualHit(dualHit), .txMode(txMode), .evtIrq(evtIrq)
  );

  task automatic check(input logic act, input logic expv, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, expv);
    end
  endtask

  // Monitor: byte seen at a rising edge, results compared at the next falling edge
  always @(posedge clk) tbSaw <= byteValid;

  always @(negedge clk) begin
    if (tbSaw) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=byte expected=none");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(ackOut, e.ack, {e.req, " ackOut"});
        check(addrMatched, e.flag, {e.req, " addrMatched"});
        check(txMode, e.tx, {e.req, " txMode"});
        check(dualHit, e.dual, {e.req, " dualHit"});
      end
    end
  end

  task automatic sendByte(input logic [7:0] b, input logic eAck, input logic eFlag,
                          input logic eTx, input logic eDual, input string req);
    exp_t e;
    e.ack = eAck; e.flag = eFlag; e.tx = eTx; e.dual = eDual; e.req = req;
    @(negedge clk);
    byteData  = b;
    byteValid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic doStart;
    @(negedge clk); startStb = 1'b1; @(negedge clk); startStb = 1'b0;
  endtask
  task automatic doRstart;
    @(negedge clk); rstartStb = 1'b1; @(negedge clk); rstartStb = 1'b0;
  endtask
  task automatic doStop;
    @(negedge clk); stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
  endtask
  task automatic readOne;
    @(negedge clk); sr1Read = 1'b1; @(negedge clk); sr1Read = 1'b0;
  endtask
  task automatic readTwo;
    @(negedge clk); sr2Read = 1'b1; @(negedge clk); sr2Read = 1'b0;
  endtask
  task automatic clearFlag;
    readOne(); readTwo();
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    check(ackOut, 1'b0, "R1 reset ackOut");
    check(addrMatched, 1'b0, "R1 reset addrMatched");
    check(txMode, 1'b0, "R4 reset txMode");
    check(evtIrq, 1'b0, "R7 reset evtIrq");

    // R1 / R4: 7-bit write match, then data byte not acked (R9)
    doStart();
    sendByte(8'h4A, 1, 1, 0, 0, "R1 7-bit write match");
    check(evtIrq, 1'b1, "R7 irq with flag and enable");
    sendByte(8'h4A, 0, 1, 0, 0, "R9 data byte after match");
    doStop();
    check(txMode, 1'b0, "R4 stop clears txMode");
    readTwo();
    check(addrMatched, 1'b1, "R8 second read alone keeps flag");
    clearFlag();
    check(addrMatched, 1'b0, "R8 two-step clear");
    check(evtIrq, 1'b0, "R7 irq drops with flag");

    // R4: read direction
    doStart();
    sendByte(8'h4B, 1, 1, 1, 0, "R4 7-bit read match");
    doStop();
    evtIrqEnable = 1'b0;
    @(negedge clk);
    check(evtIrq, 1'b0, "R7 irq masked");
    evtIrqEnable = 1'b1;
    clearFlag();

    // R2: acknowledge disabled
    ackEnable = 1'b0;
    doStart();
    sendByte(8'h4A, 0, 1, 0, 0, "R2 match without ack");
    doStop();
    clearFlag();
    ackEnable = 1'b1;

    // R3: second address
    doStart();
    sendByte(8'h78, 0, 0, 0, 0, "R3 addr2 with dual off");
    doStop();
    dualEnable = 1'b1;
    doStart();
    sendByte(8'h78, 1, 1, 0, 1, "R3 addr2 with dual on");
    doStop();
    clearFlag();
    doStart();
    sendByte(8'h4B, 1, 1, 1, 0, "R3 addr1 clears dualHit");
    doStop();
    clearFlag();
    dualEnable = 1'b0;

    // R9: nonmatch returns to idle
    doStart();
    sendByte(8'h10, 0, 0, 0, 0, "R9 nonmatching address");
    sendByte(8'h4A, 0, 0, 0, 0, "R9 idle after nonmatch");
    doStop();

    // R5 / R6: 10-bit write then repeated-start read
    tenBitMode = 1'b1;
    doStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R5 10-bit write header");
    sendByte(8'hA5, 1, 1, 0, 0, "R5 10-bit low byte");
    clearFlag();
    doRstart();
    sendByte(8'hF5, 1, 1, 1, 0, "R6 read header after rstart");
    doStop();
    clearFlag();

    // R6: unarmed read header
    doStart();
    sendByte(8'hF5, 0, 0, 0, 0, "R6 read header unarmed");
    doStop();

    // R10: wrong high bits
    doStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R5 header before R10");
    sendByte(8'hA5, 1, 1, 0, 0, "R5 low before R10");
    clearFlag();
    doRstart();
    sendByte(8'hF3, 0, 0, 0, 0, "R10 wrong high bits");
    doStop();

    // R5: wrong low byte
    doStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R5 header");
    sendByte(8'hA4, 0, 0, 0, 0, "R5 wrong low byte");
    doStop();

    // R6: stop forgets the 10-bit match
    doStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R5 header again");
    sendByte(8'hA5, 1, 1, 0, 0, "R5 low again");
    clearFlag();
    doStop();
    doStart();
    sendByte(8'hF5, 0, 0, 0, 0, "R6 read after stop");
    doStop();

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d left expected=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule